// File: doc/BRIEF.md
# Break-Aware Two-Step Status Flag Unit

This block keeps the status flags of a serial peripheral. Each flag is set by a single-cycle pulse from the hardware that reports an event. Software clears a flag in two steps. First it reads the status register while the flag is set, which arms that flag. Then it accesses the data register, which clears every armed flag in one go. The flags and their armed bits both live in this unit, so the peripheral needs only the read and access strobes from its register decoder.

A debug break input and a one-bit control register set how accesses made while the processor is halted are treated. With the control bit at 0, a break freezes the whole clearing path. Register accesses made by the debugger then cannot disarm, arm or clear anything, and a flag armed before the break can still be cleared by the data access that follows the break. With the control bit at 1, accesses made during a break clear flags as usual. A flag cleared this way stays cleared once the break ends. Hardware events set flags at all times.

Top module: `sflag_unit`

## Requirements
- R1: Reset is synchronous and active high. After it, every flag is 0, no flag is armed and the break-clear control bit reads 0.
- R2: A 1 on bit i of `evt_set` makes `flags[i]` read 1 after the next clock edge. This holds during a break, whatever the control bit is.
- R3: A status read while a flag is 1 arms it. A later data access clears an armed flag at the next edge. A data access with no earlier arming read leaves the flag at 1. A status read made while the flag is 0 arms nothing.
- R4: One data access clears every armed flag together. Flags that were set after the arming read are not armed and stay 1.
- R5: While `brk_active` is 1 and the control bit is 0, status reads and data accesses leave every flag unchanged.
- R6: While `brk_active` is 1 and the control bit is 0, arming is frozen. A read made in that state arms nothing. An arming made before the break is not used up by a data access during the break, and the first data access after the break clears that flag.
- R7: With the control bit at 1, the two-step sequence clears flags during a break, and those flags are still 0 after `brk_active` returns to 0.
- R8: A set event that arrives in the same cycle as a clearing data access wins, so the flag stays 1. The event also disarms the flag, so a later data access without a new status read leaves it at 1.
- R9: A cycle with `bce_wr` at 1 loads `bce_din` into the control bit, and the new value shows on `bce_q` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | NF | Per-flag hardware set pulses |
| stat_rd | input | 1 | Status register read strobe |
| data_acc | input | 1 | Data register access strobe (read or write) |
| brk_active | input | 1 | Debug break state is active |
| bce_wr | input | 1 | Write strobe for the break-clear control bit |
| bce_din | input | 1 | Value written to the control bit |
| bce_q | output | 1 | Current break-clear control bit |
| flags | output | NF | Status flag outputs |

## Verification
The bench builds the unit with the default of four flags. That width lets one test arm some flags and leave others unarmed, then show that a single data access clears only the armed ones. With four flags the bench can also mix different flags inside a break, such as a flag armed before the break next to a flag set by an event during it. The same width covers a set event that arrives in the same cycle as the clearing access.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    // Register-access strobes after break qualification
    typedef struct packed {
        logic rd;
        logic acc;
    } sflag_acc_t;

    // Per-flag state
    typedef struct packed {
        logic flag;
        logic armed;
    } sflag_state_t;

    localparam sflag_state_t SFLAG_IDLE = '{flag: 1'b0, armed: 1'b0};

    // Accesses are blocked when halted and clearing is not permitted
    function automatic logic sflag_frozen(input logic brk, input logic bce);
        return brk & ~bce;
    endfunction

    // Next state of one flag
    function automatic sflag_state_t sflag_next(input sflag_state_t cur,
                                                input logic evt,
                                                input sflag_acc_t a);
        sflag_state_t nx;
        nx = cur;
        if (evt) begin
            nx.flag  = 1'b1;
            nx.armed = 1'b0;
        end else if (a.acc && cur.armed) begin
            nx.flag  = 1'b0;
            nx.armed = 1'b0;
        end else if (a.rd && cur.flag) begin
            nx.armed = 1'b1;
        end
        return nx;
    endfunction

endpackage

// File: rtl/sflag_ctrl.sv
module sflag_ctrl
    import sflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stat_rd,
    input  logic       data_acc,
    input  logic       brk_active,
    input  logic       bce_wr,
    input  logic       bce_din,
    output logic       bce_q,
    output logic       frozen,
    output sflag_acc_t qual
);

    always_ff @(posedge clk) begin
        if (rst)
            bce_q <= 1'b0;
        else if (bce_wr)
            bce_q <= bce_din;
    end

    always_comb begin
        frozen   = sflag_frozen(brk_active, bce_q);
        qual.rd  = stat_rd  & ~frozen;
        qual.acc = data_acc & ~frozen;
    end

    p_bce_load_r9: assert property (@(posedge clk) disable iff (rst)
        bce_wr |=> (bce_q == $past(bce_din)));

    p_bce_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bce_wr |=> $stable(bce_q));

endmodule

// File: rtl/sflag_cell.sv
module sflag_cell
    import sflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       frozen,
    input  sflag_acc_t qual,
    output logic       flag
);

    sflag_state_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= SFLAG_IDLE;
        else
            st <= sflag_next(st, evt, qual);
    end

    assign flag = st.flag;

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        evt |=> (st.flag && !st.armed));

    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (frozen && !evt) |=> ($stable(st.flag) && $stable(st.armed)));

    p_clear_needs_arm_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(st.flag) |-> ($past(st.armed) && $past(qual.acc)));

    p_arm_needs_read_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(st.armed) |-> ($past(qual.rd) && $past(st.flag)));

endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
    import sflag_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] evt_set,
    input  logic          stat_rd,
    input  logic          data_acc,
    input  logic          brk_active,
    input  logic          bce_wr,
    input  logic          bce_din,
    output logic          bce_q,
    output logic [NF-1:0] flags
);

    logic       frozen;
    sflag_acc_t qual;

    sflag_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .stat_rd    (stat_rd),
        .data_acc   (data_acc),
        .brk_active (brk_active),
        .bce_wr     (bce_wr),
        .bce_din    (bce_din),
        .bce_q      (bce_q),
        .frozen     (frozen),
        .qual       (qual)
    );

    for (genvar i = 0; i < NF; i++) begin : g_cell
        sflag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .evt    (evt_set[i]),
            .frozen (frozen),
            .qual   (qual),
            .flag   (flags[i])
        );
    end

endmodule

// File: tb/sflag_unit_bench.sv
module sflag_unit_bench;

    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NF-1:0] evt_set;
    logic          stat_rd, data_acc, brk_active, bce_wr, bce_din;
    logic          bce_q;
    logic [NF-1:0] flags;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sflag_unit #(.NF(NF)) u_sflag_unit (
        .clk(clk), .rst(rst), .evt_set(evt_set), .stat_rd(stat_rd),
        .data_acc(data_acc), .brk_active(brk_active), .bce_wr(bce_wr),
        .bce_din(bce_din), .bce_q(bce_q), .flags(flags)
    );

    task automatic chk(input string req, input logic [NF-1:0] act,
                       input logic [NF-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle of strobes, driven after a falling edge, result visible at the next one
    task automatic step(input logic [NF-1:0] e, input logic rd, input logic acc);
        evt_set = e; stat_rd = rd; data_acc = acc;
        @(negedge clk);
        evt_set = '0; stat_rd = 1'b0; data_acc = 1'b0;
    endtask

    task automatic wr_bce(input logic v);
        bce_wr = 1'b1; bce_din = v;
        @(negedge clk);
        bce_wr = 1'b0; bce_din = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 flags", flags, '0);
        chk("R1 bce", {{(NF-1){1'b0}}, bce_q}, '0);
        step('0, 1'b0, 1'b1);
        chk("R1 no arm after reset", flags, '0);
    endtask

    task automatic t_set_and_clear;
        step(4'b0001, 1'b0, 1'b0);
        chk("R2 set", flags, 4'b0001);
        step('0, 1'b0, 1'b1);
        chk("R3 access without read", flags, 4'b0001);
        step('0, 1'b1, 1'b0);
        chk("R3 read keeps flag", flags, 4'b0001);
        step('0, 1'b0, 1'b1);
        chk("R3 two-step clear", flags, 4'b0000);
        step('0, 1'b1, 1'b0);
        step(4'b0010, 1'b0, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R3 read while zero arms nothing", flags, 4'b0010);
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R3 cleanup", flags, 4'b0000);
    endtask

    task automatic t_multi;
        step(4'b0110, 1'b0, 1'b0);
        step('0, 1'b1, 1'b0);
        step(4'b1000, 1'b0, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R4 only armed cleared", flags, 4'b1000);
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R4 cleanup", flags, 4'b0000);
    endtask

    task automatic t_frozen_read;
        step(4'b0001, 1'b0, 1'b0);
        brk_active = 1'b1;
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R5 frozen accesses", flags, 4'b0001);
        step(4'b0100, 1'b0, 1'b0);
        chk("R2 set during break", flags, 4'b0101);
        brk_active = 1'b0;
        step('0, 1'b0, 1'b1);
        chk("R6 frozen read did not arm", flags, 4'b0101);
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R6 cleanup", flags, 4'b0000);
    endtask

    task automatic t_armed_before;
        step(4'b0011, 1'b0, 1'b0);
        step('0, 1'b1, 1'b0);
        brk_active = 1'b1;
        step('0, 1'b0, 1'b1);
        step('0, 1'b0, 1'b1);
        chk("R5 armed flags held in break", flags, 4'b0011);
        brk_active = 1'b0;
        step('0, 1'b0, 1'b1);
        chk("R6 arming kept through break", flags, 4'b0000);
    endtask

    task automatic t_bce;
        wr_bce(1'b1);
        chk("R9 load 1", {{(NF-1){1'b0}}, bce_q}, 4'b0001);
        step(4'b1001, 1'b0, 1'b0);
        brk_active = 1'b1;
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R7 clear in break", flags, 4'b0000);
        brk_active = 1'b0;
        @(negedge clk);
        chk("R7 stays clear", flags, 4'b0000);
        wr_bce(1'b0);
        chk("R9 load 0", {{(NF-1){1'b0}}, bce_q}, 4'b0000);
    endtask

    task automatic t_race;
        step(4'b0001, 1'b0, 1'b0);
        step('0, 1'b1, 1'b0);
        step(4'b0001, 1'b0, 1'b1);
        chk("R8 event wins", flags, 4'b0001);
        step('0, 1'b0, 1'b1);
        chk("R8 event disarms", flags, 4'b0001);
        step('0, 1'b1, 1'b0);
        step('0, 1'b0, 1'b1);
        chk("R8 cleanup", flags, 4'b0000);
    endtask

    initial begin
        rst = 1'b1; evt_set = '0; stat_rd = 1'b0; data_acc = 1'b0;
        brk_active = 1'b0; bce_wr = 1'b0; bce_din = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_and_clear();
        t_multi();
        t_frozen_read();
        t_armed_before();
        t_bce();
        t_race();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #20000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule